// File: doc/BRIEF.md
# Memory Port Write Request Sequencer

This block sits on the master side of a native memory-controller port and turns user commands into transfers on that port. The port has a write-data FIFO, fed by single-cycle push strobes that carry a 64-bit word and its byte enables. It also has an address phase, made of a request line that is held until the controller acknowledges it. A user command supplies a start address, a size code, a read flag and a byte-reversal flag. The user then feeds the write beats through a valid/ready stream.

The size of the transfer decides the order of the two phases. On a 64-bit memory, a single-beat write (a word or a double-word) must have its address accepted before its data is pushed. Otherwise the controller consumes a stale FIFO entry. A burst write is the other way round: every beat must already be in the FIFO before the address goes out. A read uses the address phase only. Only one transfer is outstanding at a time. The block reports `busy` while a transfer runs and pulses `done` when it finishes.

Top module: `wr_port_sequencer`

## Requirements
- R1: After a synchronous reset, `addrReq`, `pushStb`, `busy`, `dataReady` and `done` are all low.
- R2: A command with `cmdRead`=1 raises `addrReq` with `reqRead`=1 and issues no push, whatever the size code.
- R3: A write with size code 0 (word) or 1 (double-word) raises `addrReq` first. Its single push comes at least one cycle after the cycle in which `addrAck` is high.
- R4: A write with size code 2..6 is a burst of 4, 8, 16, 32 or 64 words, which takes 2, 4, 8, 16 or 32 pushes. Code 7 is treated as code 6. Every push of a burst occurs before `addrReq` rises.
- R5: `addrReq` stays high until a cycle with `addrAck` high and is low in the next cycle. `reqAddr`, `reqSize` and `reqRead` equal the command's values and stay stable while the request is high.
- R6: Each accepted user beat (`dataValid` and `dataReady` high in the same cycle) produces exactly one one-cycle `pushStb`. The push comes in the next cycle and carries that beat's data and enables. Idle gaps of any length between beats are allowed.
- R7: For size code 0, `pushBe` keeps only the enables of one 32-bit half. Address bit 2 = 1 selects bytes 7:4, and 0 selects bytes 3:0. The other sizes pass all enables.
- R8: With `cmdSwap`=1, the byte order inside each 32-bit half is reversed: byte k of a half moves to byte 3-k of that half. The enable bits are reversed the same way.
- R9: `busy` is high from the cycle after a command is accepted until the transfer ends. A `cmdValid` seen while `busy` is high is ignored.
- R10: `done` pulses for one cycle when a transfer ends, in the same cycle in which `busy` falls. A read or a burst ends in the cycle after its acknowledge. A single-beat write ends in its push cycle.
- R11: No push occurs while `addrReq` is high, so all pushes of an earlier transfer are finished before the next request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command strobe, taken when not busy |
| cmdAddr | input | ADDR_W | Start byte address |
| cmdSize | input | 3 | Size code: 0 word, 1 double-word, 2..7 bursts |
| cmdRead | input | 1 | 1 = read transfer |
| cmdSwap | input | 1 | 1 = reverse bytes within each 32-bit half |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| dataValid | input | 1 | User write beat valid |
| dataWord | input | DATA_W | User write beat data |
| dataBe | input | DATA_W/8 | User write beat byte enables |
| dataReady | output | 1 | Sequencer accepts a beat this cycle |
| addrReq | output | 1 | Address request to the port |
| addrAck | input | 1 | Address acknowledge from the port |
| reqAddr | output | ADDR_W | Address presented with the request |
| reqSize | output | 3 | Size code presented with the request |
| reqRead | output | 1 | Read flag presented with the request |
| pushStb | output | 1 | Write FIFO push strobe |
| pushData | output | DATA_W | Push data |
| pushBe | output | DATA_W/8 | Push byte enables |

## Verification
A push is due one cycle after the user handshake that produced it. After an acknowledge, `addrReq` drops in the next cycle. A burst's request rises two cycles after its last beat handshake, which is one cycle after its last push. `done` comes one cycle after the acknowledge for reads and bursts, and in the push cycle for single-beat writes. The bench samples every output on the falling edge and stamps each event with the number of the cycle it belongs to. It then compares those stamps (push against acknowledge, last push against request rise, request fall against acknowledge plus one, `done` against the `busy` fall) and does not rely on fixed waits.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  // size codes whose meaning the control and datapath share
  localparam logic [2:0] SZ_WORD  = 3'd0;
  localparam logic [2:0] SZ_DWORD = 3'd1;
  localparam logic [2:0] SZ_BURST = 3'd2;  // first burst code

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_PUSH  = 2'd2,
    ST_DRAIN = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture command
    logic take;  // accept one user beat
  } seqCtrl_t;
endpackage

// File: rtl/wseq_datapath.sv
module wseq_datapath
  import wseq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int MAX_PUSH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  seqCtrl_t            ctrl,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [2:0]          cmdSize,
  input  logic                cmdRead,
  input  logic                cmdSwap,
  input  logic [DATA_W-1:0]   dataWord,
  input  logic [DATA_W/8-1:0] dataBe,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [2:0]          reqSize,
  output logic                reqRead,
  output logic                isBurst,
  output logic                lastBeat,
  output logic                pushStb,
  output logic [DATA_W-1:0]   pushData,
  output logic [DATA_W/8-1:0] pushBe
);
  localparam int BE_W     = DATA_W / 8;
  localparam int LANES    = DATA_W / 32;
  localparam int CNT_W    = $clog2(MAX_PUSH) + 1;
  localparam int TOP_CODE = $clog2(MAX_PUSH) + 1;

  logic [ADDR_W-1:0] regAddr;
  logic [2:0]        regSize;
  logic              regRead, regSwap;
  logic [CNT_W-1:0]  beatsLeft;
  logic [DATA_W-1:0] swData, selData;
  logic [BE_W-1:0]   swBe, selBe, halfMask;

  function automatic logic [CNT_W-1:0] pushCount(input logic [2:0] sz);
    logic [2:0] sh;
    if (sz < SZ_BURST) return CNT_W'(1);
    sh = (sz >= 3'(TOP_CODE)) ? 3'(TOP_CODE - 1) : sz - 3'd1;
    return CNT_W'(1) << sh;
  endfunction

  // byte reversal inside every 32-bit lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign swData[l*32 + b*8 +: 8] = dataWord[l*32 + (3-b)*8 +: 8];
      assign swBe[l*4 + b]           = dataBe[l*4 + 3 - b];
    end
  end

  always_comb begin
    selData  = regSwap ? swData : dataWord;
    selBe    = regSwap ? swBe   : dataBe;
    halfMask = '1;
    if (regSize == SZ_WORD)
      halfMask = {{(BE_W/2){regAddr[2]}}, {(BE_W/2){~regAddr[2]}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regAddr   <= '0;
      regSize   <= '0;
      regRead   <= 1'b0;
      regSwap   <= 1'b0;
      beatsLeft <= '0;
      pushStb   <= 1'b0;
      pushData  <= '0;
      pushBe    <= '0;
    end else begin
      pushStb <= ctrl.take;
      if (ctrl.load) begin
        regAddr   <= cmdAddr;
        regSize   <= cmdSize;
        regRead   <= cmdRead;
        regSwap   <= cmdSwap;
        beatsLeft <= cmdRead ? '0 : pushCount(cmdSize);
      end
      if (ctrl.take) begin
        beatsLeft <= beatsLeft - CNT_W'(1);
        pushData  <= selData;
        pushBe    <= selBe & halfMask;
      end
    end
  end

  assign reqAddr  = regAddr;
  assign reqSize  = regSize;
  assign reqRead  = regRead;
  assign isBurst  = !regRead && (regSize >= SZ_BURST);
  assign lastBeat = (beatsLeft == CNT_W'(1));

  // R6: a beat is only taken while one is still owed
  p_take_owed_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.take |-> beatsLeft != '0);
  // R6: a taken beat appears as a push on the next cycle
  p_take_pushes_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.take |=> pushStb);
endmodule

// File: rtl/wseq_control.sv
module wseq_control
  import wseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [2:0] cmdSize,
  input  logic       cmdRead,
  input  logic       dataValid,
  input  logic       addrAck,
  input  logic       isRead,
  input  logic       isBurst,
  input  logic       lastBeat,
  output seqCtrl_t   ctrl,
  output logic       addrReq,
  output logic       dataReady,
  output logic       busy,
  output logic       done
);
  seqState_t stateQ, stateD;
  logic      doneQ, doneD;
  logic      cmdBurst;

  assign cmdBurst = !cmdRead && (cmdSize >= SZ_BURST);

  always_comb begin
    stateD = stateQ;
    doneD  = 1'b0;
    ctrl   = '0;
    case (stateQ)
      ST_IDLE: if (cmdValid) begin
        ctrl.load = 1'b1;
        stateD    = cmdBurst ? ST_PUSH : ST_ADDR;
      end
      ST_ADDR: if (addrAck) begin
        if (isRead || isBurst) begin
          stateD = ST_IDLE;
          doneD  = 1'b1;
        end else begin
          stateD = ST_PUSH;
        end
      end
      ST_PUSH: if (dataValid) begin
        ctrl.take = 1'b1;
        if (lastBeat) begin
          if (isBurst) begin
            stateD = ST_DRAIN;
          end else begin
            stateD = ST_IDLE;
            doneD  = 1'b1;
          end
        end
      end
      default: stateD = ST_ADDR;  // drain: let the last push leave first
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
    end
  end

  assign addrReq   = (stateQ == ST_ADDR);
  assign dataReady = (stateQ == ST_PUSH);
  assign busy      = (stateQ != ST_IDLE);
  assign done      = doneQ;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !addrReq && !busy && !done);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    addrReq && !addrAck |=> addrReq);
  p_req_drop_r5: assert property (@(posedge clk) disable iff (rst)
    addrReq && addrAck |=> !addrReq);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy && cmdValid |-> !ctrl.load);
endmodule

// File: rtl/wr_port_sequencer.sv
module wr_port_sequencer
  import wseq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int MAX_PUSH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdValid,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [2:0]          cmdSize,
  input  logic                cmdRead,
  input  logic                cmdSwap,
  output logic                busy,
  output logic                done,
  input  logic                dataValid,
  input  logic [DATA_W-1:0]   dataWord,
  input  logic [DATA_W/8-1:0] dataBe,
  output logic                dataReady,
  output logic                addrReq,
  input  logic                addrAck,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [2:0]          reqSize,
  output logic                reqRead,
  output logic                pushStb,
  output logic [DATA_W-1:0]   pushData,
  output logic [DATA_W/8-1:0] pushBe
);
  seqCtrl_t ctrl;
  logic     isBurst, lastBeat;

  wseq_control u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdSize(cmdSize),
    .cmdRead(cmdRead), .dataValid(dataValid), .addrAck(addrAck),
    .isRead(reqRead), .isBurst(isBurst), .lastBeat(lastBeat),
    .ctrl(ctrl), .addrReq(addrReq), .dataReady(dataReady),
    .busy(busy), .done(done)
  );

  wseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PUSH(MAX_PUSH)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .cmdAddr(cmdAddr),
    .cmdSize(cmdSize), .cmdRead(cmdRead), .cmdSwap(cmdSwap),
    .dataWord(dataWord), .dataBe(dataBe), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqRead(reqRead), .isBurst(isBurst),
    .lastBeat(lastBeat), .pushStb(pushStb), .pushData(pushData),
    .pushBe(pushBe)
  );

  p_no_push_in_req_r11: assert property (@(posedge clk) disable iff (rst)
    pushStb |-> !addrReq);
  p_req_stable_r5: assert property (@(posedge clk) disable iff (rst)
    addrReq && $past(addrReq) |-> $stable(reqAddr) && $stable(reqSize) && $stable(reqRead));
  p_read_no_push_r2: assert property (@(posedge clk) disable iff (rst)
    busy && reqRead |-> !pushStb && !dataReady);
  p_push_not_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
    addrAck && addrReq |-> !pushStb);
endmodule

// File: tb/wr_port_sequencer_bench.sv
`timescale 1ns/1ps
module wr_port_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0, cmdRead = 1'b0, cmdSwap = 1'b0;
  logic [31:0] cmdAddr = '0;
  logic [2:0]  cmdSize = '0;
  logic        dataValid = 1'b0;
  logic [63:0] dataWord = '0;
  logic [7:0]  dataBe = '0;
  logic        addrAck = 1'b0;
  logic        busy, done, dataReady, addrReq, reqRead, pushStb;
  logic [31:0] reqAddr;
  logic [2:0]  reqSize;
  logic [63:0] pushData;
  logic [7:0]  pushBe;

  wr_port_sequencer u_wr_port_sequencer (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdSize(cmdSize), .cmdRead(cmdRead), .cmdSwap(cmdSwap),
    .busy(busy), .done(done), .dataValid(dataValid), .dataWord(dataWord),
    .dataBe(dataBe), .dataReady(dataReady), .addrReq(addrReq),
    .addrAck(addrAck), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqRead(reqRead), .pushStb(pushStb), .pushData(pushData),
    .pushBe(pushBe)
  );

  always #10 clk = ~clk;  // 50 MHz

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor / acknowledge responder state
  logic [63:0] logData [0:63];
  logic [7:0]  logBe   [0:63];
  int pushN, firstPushCyc, lastPushCyc, reqRiseN, reqRiseCyc, reqFallCyc;
  int ackCyc, doneN, doneCyc, busyFallCyc, ackDelay, pushInReq;
  logic [31:0] seenAddr; logic [2:0] seenSize; logic seenRead;
  logic prevReq = 1'b0, prevBusy = 1'b0;

  always @(negedge clk) begin
    if (pushStb) begin
      if (pushN < 64) begin logData[pushN] = pushData; logBe[pushN] = pushBe; end
      if (pushN == 0) firstPushCyc = cyc;
      lastPushCyc = cyc;
      pushN++;
      if (addrReq) pushInReq++;
    end
    if (addrReq && !prevReq) begin
      reqRiseN++; reqRiseCyc = cyc;
      seenAddr = reqAddr; seenSize = reqSize; seenRead = reqRead;
    end
    if (!addrReq && prevReq) reqFallCyc = cyc;
    if (done) begin doneN++; doneCyc = cyc; end
    if (!busy && prevBusy) busyFallCyc = cyc;
    prevReq = addrReq; prevBusy = busy;
    if (addrAck) addrAck = 1'b0;
    else if (addrReq) begin
      if (ackDelay == 0) begin addrAck = 1'b1; ackCyc = cyc; end
      else ackDelay--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expData(input logic [63:0] d, input bit sw);
    logic [63:0] r = d;
    if (sw) for (int l = 0; l < 2; l++) for (int b = 0; b < 4; b++)
      r[l*32 + b*8 +: 8] = d[l*32 + (3-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] expBe(input logic [7:0] be, input bit sw,
                                       input logic [2:0] sz, input logic [31:0] a);
    logic [7:0] r = be;
    if (sw) for (int l = 0; l < 2; l++) for (int b = 0; b < 4; b++)
      r[l*4 + b] = be[l*4 + 3 - b];
    if (sz == 3'd0) r = r & (a[2] ? 8'hF0 : 8'h0F);
    return r;
  endfunction

  function automatic int expBeats(input logic [2:0] sz, input bit rd);
    if (rd) return 0;
    if (sz < 3'd2) return 1;
    return 1 << ((sz == 3'd7 ? 6 : int'(sz)) - 1);
  endfunction

  task automatic runTxn(input logic [31:0] a, input logic [2:0] sz, input bit rd,
                        input bit sw, input int maxGap, input bit poke);
    int nBeats = expBeats(sz, rd);
    int sent = 0, gap = 0, loops = 0;
    logic [63:0] w [0:31];
    logic [7:0]  e [0:31];
    for (int i = 0; i < 32; i++) begin
      w[i] = {$urandom, $urandom}; e[i] = 8'($urandom);
    end
    pushN = 0; reqRiseN = 0; doneN = 0; pushInReq = 0;
    firstPushCyc = -1; lastPushCyc = -1; reqRiseCyc = -1; reqFallCyc = -1;
    ackCyc = -1; doneCyc = -1; busyFallCyc = -1;
    ackDelay = int'($urandom % 4);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = a; cmdSize = sz; cmdRead = rd; cmdSwap = sw;
    @(negedge clk);
    chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    if (poke) begin
      cmdAddr = ~a; cmdRead = ~rd; cmdSize = 3'd1;  // must be ignored
    end else cmdValid = 1'b0;
    while (doneN == 0 && loops < 2000) begin
      if (loops == 0) begin
        // first loop iteration happens in the same half cycle as the poke
      end
      if (sent < nBeats && dataReady && gap == 0) begin
        dataValid = 1'b1; dataWord = w[sent]; dataBe = e[sent];
        sent++; gap = (maxGap > 0) ? int'($urandom % (maxGap + 1)) : 0;
      end else begin
        dataValid = 1'b0;
        if (gap > 0) gap--;
      end
      @(negedge clk);
      cmdValid = 1'b0;
      loops++;
    end
    dataValid = 1'b0;
    repeat (2) @(negedge clk);
    chk(reqRiseN == 1, "R9 one request per command", 64'(reqRiseN), 64'd1);
    chk(seenAddr == a && seenSize == sz && seenRead == rd, "R5 request fields",
        {seenAddr, 29'(seenSize), seenRead}, {a, 29'(sz), rd});
    chk(reqFallCyc == ackCyc + 1, "R5 request drops after ack", 64'(reqFallCyc), 64'(ackCyc + 1));
    chk(pushN == nBeats, rd ? "R2 read push count" : "R4 push count", 64'(pushN), 64'(nBeats));
    for (int i = 0; i < nBeats && i < pushN; i++) begin
      chk(logData[i] == expData(w[i], sw), sw ? "R8 swapped data" : "R6 push data",
          logData[i], expData(w[i], sw));
      chk(logBe[i] == expBe(e[i], sw, sz, a), sz == 3'd0 ? "R7 word enables" : "R8 enables",
          64'(logBe[i]), 64'(expBe(e[i], sw, sz, a)));
    end
    if (!rd && nBeats > 1)
      chk(lastPushCyc >= 0 && lastPushCyc < reqRiseCyc, "R4 data before address",
          64'(lastPushCyc), 64'(reqRiseCyc));
    if (!rd && nBeats == 1)
      chk(firstPushCyc > ackCyc, "R3 push after ack", 64'(firstPushCyc), 64'(ackCyc + 1));
    chk(pushInReq == 0, "R11 no push during request", 64'(pushInReq), 64'd0);
    chk(doneN == 1 && doneCyc == busyFallCyc, "R10 done with busy fall",
        64'(doneCyc), 64'(busyFallCyc));
    if (rd || nBeats > 1)
      chk(doneCyc == ackCyc + 1, "R10 done after ack", 64'(doneCyc), 64'(ackCyc + 1));
    else
      chk(doneCyc == lastPushCyc, "R10 done in push cycle", 64'(doneCyc), 64'(lastPushCyc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({addrReq, pushStb, busy, dataReady, done} == 5'b0, "R1 reset state",
        64'({addrReq, pushStb, busy, dataReady, done}), 64'd0);
    runTxn(32'h0000_1000, 3'd3, 1'b1, 1'b0, 0, 1'b0);  // R2 read
    runTxn(32'h0000_2000, 3'd0, 1'b0, 1'b0, 0, 1'b0);  // R7 lower half
    runTxn(32'h0000_2004, 3'd0, 1'b0, 1'b1, 0, 1'b0);  // R7 upper half, R8
    runTxn(32'h0000_3000, 3'd1, 1'b0, 1'b0, 2, 1'b1);  // R3 dword, R9 poke
    runTxn(32'h0000_4000, 3'd2, 1'b0, 1'b1, 0, 1'b0);  // R4 four words
    runTxn(32'h0000_5000, 3'd3, 1'b0, 1'b0, 3, 1'b1);  // R4 eight words
    runTxn(32'h0000_6000, 3'd6, 1'b0, 1'b0, 6, 1'b0);  // R4 64 words, gaps R6
    runTxn(32'h0000_7000, 3'd7, 1'b0, 1'b1, 0, 1'b0);  // R4 code 7
    for (int k = 0; k < 40; k++)
      runTxn({$urandom} & 32'hFFFF_FFFC, 3'($urandom), ($urandom % 5) == 0,
             1'($urandom), int'($urandom % 4), 1'($urandom));
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule